// File: doc/BRIEF.md
# Control Register Write Validator

This block holds the five architecturally visible control registers of a 64-bit core: the machine-control word (index 0), the fault-address word (index 2), the page-table base (index 3), the feature-enable word (index 4) and the task-priority word (index 8). It has a combinational read port and one checked write port. Every write request carries an index, 64 bits of data and a flag saying whether the core is running in long mode. The block also watches the long-mode-enable bit from the extended feature register.

A write only lands in the register file after it passes two kinds of checks. The first asks whether the index exists at all. The second applies that register's own rules, some of which depend on the value already held in another register. Any fault blocks the write. One cycle later the block reports the fault as a single-cycle pulse with a 2-bit fault code. Paging side effects, translation flushes and mode changes belong to other blocks.

Top module: `ctlreg_guard`

## Requirements
- R1: After reset, index 0 reads 0x0000_0000_6000_0010 and indices 2, 3, 4 and 8 read zero.
- R2: A write to index 1, 5, 6, 7 or any index above 8 is not committed and reports fault code 1 (invalid opcode). A read of such an index raises `rd_bad` and returns zero.
- R3: A write to index 0 with any of bits 63:32 set reports fault code 2 (protection) and is not committed.
- R4: A write to index 0 faults with code 2 in two cases: bit 31 (paging) is set while bit 0 (protection) is clear, or bit 29 (no write-through) is set while bit 30 (cache disable) is clear.
- R5: A write to index 0 with bit 31 set faults with code 2 while `lme` is high and bit 5 of the stored index-4 register is clear. The same write is accepted when that bit is set.
- R6: Writes to indices 2 and 3 are accepted for every data value.
- R7: A write to index 4 faults with code 2 when any of bits 63:11 is set, or when `wr_long` is high and bit 5 of the data is clear.
- R8: A write to index 8 faults with code 2 when any of bits 63:4 is set.
- R9: `flt_valid` is high for exactly the one cycle after a faulting write request, with `flt_code` showing the fault. After an accepted write or an idle cycle, `flt_valid` is low and `flt_code` is 0.
- R10: A read in the same cycle as a write to the same index returns the old value. An accepted write becomes visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 4 | Read index |
| rd_data | output | 64 | Stored value of the read index, zero if the index is invalid |
| rd_bad | output | 1 | Read index is not an implemented register |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write index |
| wr_data | input | 64 | Write data |
| wr_long | input | 1 | Core is in long mode for this request |
| lme | input | 1 | Long-mode-enable bit of the extended feature register |
| flt_valid | output | 1 | One-cycle fault pulse |
| flt_code | output | 2 | 0 none, 1 invalid opcode, 2 protection |

## Verification
A read and a write can fall in the same cycle. To provoke this, the bench drives `rd_idx` and `wr_idx` to the same register while the write is pending. It then checks that `rd_data` still shows the old value before the clock edge and shows the new value after it. The rule in R5 also makes the machine-control check depend on the stored feature word. The bench therefore sweeps every combination of the four control bits against both values of that stored bit and both values of `lme`. Each expected fault is worked out arithmetically in the bench.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_BADIDX = 2'd1,
    FLT_PROT   = 2'd2
  } flt_e;

  localparam int NSLOT   = 5;
  localparam int SLOT_W  = $clog2(NSLOT);

  localparam int SL_CTL  = 0;
  localparam int SL_FADR = 1;
  localparam int SL_PTB  = 2;
  localparam int SL_FEAT = 3;
  localparam int SL_PRIO = 4;

  localparam int B_PROT  = 0;
  localparam int B_NWT   = 29;
  localparam int B_CDIS  = 30;
  localparam int B_PAGE  = 31;
  localparam int B_PAE   = 5;

  localparam logic [63:0] CTL_RST = 64'h0000_0000_6000_0010;

endpackage

// File: rtl/ctlreg_idx_map.sv
module ctlreg_idx_map
  import ctlreg_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0]  idx,
  output logic              ok,
  output logic [SLOT_W-1:0] slot
);

  always_comb begin
    ok   = 1'b1;
    slot = '0;
    case (idx)
      IDX_W'(0): slot = SLOT_W'(SL_CTL);
      IDX_W'(2): slot = SLOT_W'(SL_FADR);
      IDX_W'(3): slot = SLOT_W'(SL_PTB);
      IDX_W'(4): slot = SLOT_W'(SL_FEAT);
      IDX_W'(8): slot = SLOT_W'(SL_PRIO);
      default:   ok   = 1'b0;
    endcase
  end

endmodule

// File: rtl/ctlreg_wr_rules.sv
module ctlreg_wr_rules
  import ctlreg_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int CTL_HI   = 32,
  parameter int FEAT_HI  = 11,
  parameter int PRIO_HI  = 4
) (
  input  logic              req,
  input  logic              ok,
  input  logic [SLOT_W-1:0] slot,
  input  logic [XLEN-1:0]   data,
  input  logic              in_long,
  input  logic              lme,
  input  logic [XLEN-1:0]   cur_feat,
  output flt_e              code
);

  logic ctl_bad, feat_bad, prio_bad;

  always_comb begin
    ctl_bad = ((data >> CTL_HI) != '0)
            || (data[B_PAGE] && !data[B_PROT])
            || (data[B_NWT]  && !data[B_CDIS])
            || (data[B_PAGE] && lme && !cur_feat[B_PAE]);
    feat_bad = ((data >> FEAT_HI) != '0) || (in_long && !data[B_PAE]);
    prio_bad = (data >> PRIO_HI) != '0;
  end

  always_comb begin
    code = FLT_NONE;
    if (req) begin
      if (!ok) begin
        code = FLT_BADIDX;
      end else begin
        case (slot)
          SLOT_W'(SL_CTL):  if (ctl_bad)  code = FLT_PROT;
          SLOT_W'(SL_FEAT): if (feat_bad) code = FLT_PROT;
          SLOT_W'(SL_PRIO): if (prio_bad) code = FLT_PROT;
          default:          code = FLT_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int          XLEN    = 64,
  parameter logic [63:0] CTL_INI = CTL_RST
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [SLOT_W-1:0]           wslot,
  input  logic [XLEN-1:0]             wdata,
  output logic [NSLOT-1:0][XLEN-1:0]  q
);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [XLEN-1:0] INI = (s == SL_CTL) ? XLEN'(CTL_INI) : '0;
    always_ff @(posedge clk) begin
      if (rst)
        q[s] <= INI;
      else if (we && wslot == SLOT_W'(s))
        q[s] <= wdata;
    end
  end

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(q));

  a_r8_prio_narrow: assert property (@(posedge clk) disable iff (rst)
    (q[SL_PRIO] >> 4) == '0);

  a_r7_feat_narrow: assert property (@(posedge clk) disable iff (rst)
    (q[SL_FEAT] >> 11) == '0);

  a_r4_page_needs_prot: assert property (@(posedge clk) disable iff (rst)
    q[SL_CTL][B_PAGE] |-> q[SL_CTL][B_PROT]);

  a_r4_nwt_needs_cdis: assert property (@(posedge clk) disable iff (rst)
    q[SL_CTL][B_NWT] |-> q[SL_CTL][B_CDIS]);

endmodule

// File: rtl/ctlreg_guard.sv
module ctlreg_guard
  import ctlreg_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data,
  output logic             rd_bad,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             wr_long,
  input  logic             lme,
  output logic             flt_valid,
  output logic [1:0]       flt_code
);

  logic                       r_ok, w_ok;
  logic [SLOT_W-1:0]          r_slot, w_slot;
  logic [NSLOT-1:0][XLEN-1:0] regs;
  flt_e                       fcode;
  logic                       commit;

  ctlreg_idx_map #(.IDX_W(IDX_W)) u_rmap (.idx(rd_idx), .ok(r_ok), .slot(r_slot));
  ctlreg_idx_map #(.IDX_W(IDX_W)) u_wmap (.idx(wr_idx), .ok(w_ok), .slot(w_slot));

  ctlreg_wr_rules #(.XLEN(XLEN)) u_rules (
    .req(wr_en), .ok(w_ok), .slot(w_slot), .data(wr_data),
    .in_long(wr_long), .lme(lme), .cur_feat(regs[SL_FEAT]), .code(fcode)
  );

  assign commit = wr_en && (fcode == FLT_NONE);

  ctlreg_bank #(.XLEN(XLEN)) u_bank (
    .clk(clk), .rst(rst), .we(commit), .wslot(w_slot), .wdata(wr_data), .q(regs)
  );

  always_comb begin
    rd_bad  = !r_ok;
    rd_data = r_ok ? regs[r_slot] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_valid <= 1'b0;
      flt_code  <= FLT_NONE;
    end else begin
      flt_valid <= wr_en && (fcode != FLT_NONE);
      flt_code  <= fcode;
    end
  end

  a_r9_pulse_from_request: assert property (@(posedge clk) disable iff (rst)
    flt_valid |-> $past(wr_en));

  a_r9_quiet_code: assert property (@(posedge clk) disable iff (rst)
    !flt_valid |-> flt_code == FLT_NONE);

  a_r2_badidx_reported: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !w_ok) |=> (flt_valid && flt_code == FLT_BADIDX));

  a_r6_free_slots_commit: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == IDX_W'(2) || wr_idx == IDX_W'(3))) |=> !flt_valid);

endmodule

// File: tb/ctlreg_guard_tb_top.sv
module ctlreg_guard_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rd_idx, wr_idx;
  logic [63:0] rd_data, wr_data;
  logic        rd_bad, wr_en, wr_long, lme, flt_valid;
  logic [1:0]  flt_code;

  int n_chk = 0, n_fail = 0;
  logic [63:0] mdl [16];
  bit done = 0;

  always #4 clk = ~clk;

  ctlreg_guard dut_i (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_data(rd_data), .rd_bad(rd_bad),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_long(wr_long),
    .lme(lme), .flt_valid(flt_valid), .flt_code(flt_code)
  );

  function automatic bit idx_ok(int i);
    return (i == 0 || i == 2 || i == 3 || i == 4 || i == 8);
  endfunction

  function automatic logic [1:0] exp_flt(int i, logic [63:0] d, logic lg, logic le);
    if (!idx_ok(i)) return 2'd1;
    if (i == 0 && (d[63:32] != 0 || (d[31] && !d[0]) || (d[29] && !d[30]) ||
                   (d[31] && le && !mdl[4][5]))) return 2'd2;
    if (i == 4 && (d[63:11] != 0 || (lg && !d[5]))) return 2'd2;
    if (i == 8 && d[63:4] != 0) return 2'd2;
    return 2'd0;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd_chk(int i, string req);
    rd_idx = 4'(i);
    #1;
    chk(rd_bad == !idx_ok(i), req, 64'(rd_bad), 64'(!idx_ok(i)));
    chk(rd_data == (idx_ok(i) ? mdl[i] : 64'h0), req, rd_data,
        idx_ok(i) ? mdl[i] : 64'h0);
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic wr(int i, logic [63:0] d, logic lg, logic le, string req);
    logic [1:0] e;
    e = exp_flt(i, d, lg, le);
    wr_en = 1'b1; wr_idx = 4'(i); wr_data = d; wr_long = lg; lme = le;
    @(negedge clk);
    wr_en = 1'b0;
    chk(flt_valid == (e != 0), req, 64'(flt_valid), 64'(e != 0));
    chk(flt_code == e, req, 64'(flt_code), 64'(e));
    if (e == 0) mdl[i] = d;
    rd_chk(i, req);
  endtask

  initial begin
    rst = 1'b1; wr_en = 0; wr_idx = 0; wr_data = 0; wr_long = 0; lme = 0; rd_idx = 0;
    for (int i = 0; i < 16; i++) mdl[i] = 64'h0;
    mdl[0] = 64'h0000_0000_6000_0010;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R2: reset contents and read validity
    for (int i = 0; i < 16; i++) rd_chk(i, "R1");

    // R2 / R6: write to every index with a free-form pattern
    for (int i = 0; i < 16; i++) wr(i, 64'h0123_4567_89ab_c000 + 64'(i), 1'b0, 1'b0, "R2");
    // R6: extreme values into indices 2 and 3
    wr(2, 64'hffff_ffff_ffff_ffff, 1'b1, 1'b1, "R6");
    wr(3, 64'h0, 1'b1, 1'b1, "R6");
    wr(3, 64'h8000_0000_0000_0001, 1'b0, 1'b0, "R6");

    // R4 / R5: sweep the four control bits, lme and stored PAE
    for (int pae = 0; pae < 2; pae++)
      for (int le = 0; le < 2; le++)
        for (int c = 0; c < 16; c++) begin
          logic [63:0] d;
          wr(4, pae ? 64'h20 : 64'h0, 1'b0, 1'b0, "R7");
          d = 64'h10;
          d[0] = c[0]; d[29] = c[1]; d[30] = c[2]; d[31] = c[3];
          wr(0, d, 1'b0, 1'(le), (c[3] && le) ? "R5" : "R4");
        end

    // R3: each upper bit of the machine-control word
    for (int b = 32; b < 64; b++) wr(0, (64'h1 << b) | 64'h11, 1'b0, 1'b0, "R3");

    // R7: every single bit of the feature word, in and out of long mode
    for (int lg = 0; lg < 2; lg++)
      for (int b = 0; b < 64; b++) wr(4, 64'h1 << b, 1'(lg), 1'b0, "R7");
    wr(4, 64'h7ff, 1'b1, 1'b0, "R7");

    // R8: every single bit of the priority word
    for (int b = 0; b < 64; b++) wr(8, 64'h1 << b, 1'b0, 1'b0, "R8");

    // R9: pulse lasts one cycle after a faulting request
    wr(5, 64'h1, 1'b0, 1'b0, "R9");
    @(negedge clk);
    chk(flt_valid == 1'b0, "R9", 64'(flt_valid), 64'h0);
    chk(flt_code == 2'd0, "R9", 64'(flt_code), 64'h0);

    // R10: same-cycle read sees old value, new value after the edge
    rd_idx = 4'd3;
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 64'hdead_beef_0bad_f00d; wr_long = 0; lme = 0;
    #1;
    chk(rd_data == mdl[3], "R10", rd_data, mdl[3]);
    @(negedge clk);
    wr_en = 1'b0;
    mdl[3] = 64'hdead_beef_0bad_f00d;
    #1;
    chk(rd_data == mdl[3], "R10", rd_data, mdl[3]);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule